// File: doc/BRIEF.md
# Pixel Trigger Serial Link Transmitter

This block gathers the trigger pulses of a column of pixels and sends their state to a central trigger card as a framed serial word, one frame every 100 ns. It runs on the serial bit clock, where 24 bit times fill one frame period. A one-cycle frame tick, derived elsewhere from the 10 MHz timing, marks the start of each frame.

Each pixel first passes through a pulse stretcher, so that a short trigger pulse still lies under a frame tick. At the tick a two-bit per-pixel override is applied. Its high bit comes from one mask word and its low bit from another. The override either passes the live trigger, takes the matching bit of an external test-pattern word, or forces the bit low or high. A start bit is placed in front of the 22 pixel bits and an odd-parity bit after them. The word is captured and shifted out MSB first. The line rests low whenever no frame is in flight.

Top module: `ptl_tx`

## Requirements
- R1: The first bit of every frame, present on `ser_out` in the clock cycle after the cycle in which `frame_tick` is sampled high, is a start bit of value 1.
- R2: A frame is 24 bits, sent MSB first, one bit per clock. Frame bit 23 is the start bit, frame bit k+1 carries pixel k for k = 0..21, and frame bit 0 is the parity bit.
- R3: The parity bit makes the number of ones across all 24 frame bits odd.
- R4: Pixel override code {force_msb[k], force_lsb[k]} = 00 sends the stretched live trigger of pixel k.
- R5: Override code 01 sends `test_pat[k]` in place of the trigger of pixel k.
- R6: Override code 10 forces the pixel bit to 0, and code 11 forces it to 1, whatever the trigger.
- R7: A trigger of any length is held for at least 24 clocks from its rising edge, and for as long as the input stays high. A one-clock pulse between two ticks therefore appears in the next frame only.
- R8: A trigger that is held across two frame ticks is reported in both frames. It is cleared in the frame after the input falls, once the 24-clock hold from its rising edge has run out.
- R9: `ser_out` is 0 during and after reset until the first tick, and 0 from the 25th clock after a tick when no new tick arrives.
- R10: The frame content is fixed by the inputs sampled at the tick. Changes of triggers, masks or pattern during a frame do not alter the bits still being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock (24 bit times per frame) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle frame start, one every 24 clocks |
| pix_trig | input | 22 | Raw per-pixel trigger pulses |
| force_msb | input | 22 | High bit of each pixel's override code |
| force_lsb | input | 22 | Low bit of each pixel's override code |
| test_pat | input | 22 | Substitute bits for pixels with code 01 |
| ser_out | output | 1 | Serial frame output, idle low |

## Verification
A stretch counter that expires early or too late shows up as a pixel bit missing from, or lingering in, the frame after the tick. This is visible within 24 clocks of the tick that should have caught the pulse. A wrong override decode or parity bit corrupts one bit time of the very next frame. A shift or bit-count fault shifts every following bit or leaves the line high past the 24th bit. Since the bench compares the line bit by bit against its own model, any such fault is reported in the first cycle where the serial bit differs.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

  // Per-pixel override code, {msb, lsb}
  typedef enum logic [1:0] {
    OVR_LIVE    = 2'b00,
    OVR_PATTERN = 2'b01,
    OVR_LOW     = 2'b10,
    OVR_HIGH    = 2'b11
  } ovr_e;

  // Select the bit sent for one pixel
  function automatic logic pick_bit(input logic live, input logic pat,
                                    input logic msb, input logic lsb);
    logic r;
    case (ovr_e'({msb, lsb}))
      OVR_LIVE:    r = live;
      OVR_PATTERN: r = pat;
      OVR_LOW:     r = 1'b0;
      default:     r = 1'b1;
    endcase
    return r;
  endfunction

  // Bit that makes the total count of ones odd
  function automatic logic odd_fill(input logic [63:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/ptl_stretch.sv
module ptl_stretch #(
  parameter int NPIX = 22,
  parameter int HOLD = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] raw,
  output logic [NPIX-1:0] held
);
  localparam int CW = $clog2(HOLD + 1);

  for (genvar g = 0; g < NPIX; g++) begin : g_pix
    logic [CW-1:0] cnt;
    logic          prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        prev <= 1'b0;
      end else begin
        prev <= raw[g];
        if (raw[g] && !prev)
          cnt <= CW'(HOLD - 1);
        else if (cnt != '0)
          cnt <= cnt - 1'b1;
      end
    end

    assign held[g] = raw[g] | (cnt != '0);
  end
endmodule

// File: rtl/ptl_frame_build.sv
module ptl_frame_build
  import ptl_pkg::*;
#(
  parameter int NPIX = 22
) (
  input  logic [NPIX-1:0] live,
  input  logic [NPIX-1:0] pat,
  input  logic [NPIX-1:0] msb,
  input  logic [NPIX-1:0] lsb,
  output logic [NPIX+1:0] word
);
  logic [NPIX-1:0] payload;
  logic            par;

  for (genvar g = 0; g < NPIX; g++) begin : g_sel
    assign payload[g] = pick_bit(live[g], pat[g], msb[g], lsb[g]);
  end

  always_comb begin
    par  = odd_fill(64'({1'b1, payload}));
    word = {1'b1, payload, par};
  end
endmodule

// File: rtl/ptl_serializer.sv
module ptl_serializer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         busy,
  output logic         sout
);
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    shreg;
  logic [CNTW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      remain <= '0;
    end else if (load) begin
      shreg  <= word;
      remain <= CNTW'(W);
    end else if (remain != '0) begin
      shreg  <= {shreg[W-2:0], 1'b0};
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);
  assign sout = busy & shreg[W-1];
endmodule

// File: rtl/ptl_tx.sv
module ptl_tx #(
  parameter int NPIX        = 22,
  parameter int HOLD_CYCLES = NPIX + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_tick,
  input  logic [NPIX-1:0] pix_trig,
  input  logic [NPIX-1:0] force_msb,
  input  logic [NPIX-1:0] force_lsb,
  input  logic [NPIX-1:0] test_pat,
  output logic            ser_out
);
  localparam int FRAME_W = NPIX + 2;

  // Named internal events, observed by the checker
  logic [NPIX-1:0]    trig_held;
  logic [FRAME_W-1:0] frame_word;
  logic               frame_load;
  logic               link_busy;

  assign frame_load = frame_tick;

  ptl_stretch #(.NPIX(NPIX), .HOLD(HOLD_CYCLES)) u_stretch (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (pix_trig),
    .held (trig_held)
  );

  ptl_frame_build #(.NPIX(NPIX)) u_build (
    .live(trig_held),
    .pat (test_pat),
    .msb (force_msb),
    .lsb (force_lsb),
    .word(frame_word)
  );

  ptl_serializer #(.W(FRAME_W)) u_ser (
    .clk  (clk),
    .rst_n(rst_n),
    .load (frame_load),
    .word (frame_word),
    .busy (link_busy),
    .sout (ser_out)
  );
endmodule

// File: rtl/ptl_tx_chk.sv
module ptl_tx_chk #(
  parameter int NPIX = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_tick,
  input logic [NPIX-1:0] pix_trig,
  input logic [NPIX-1:0] force_msb,
  input logic [NPIX-1:0] force_lsb,
  input logic [NPIX-1:0] test_pat,
  input logic            ser_out,
  input logic [NPIX-1:0] trig_held,
  input logic [NPIX+1:0] frame_word,
  input logic            frame_load,
  input logic            link_busy
);
  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> ser_out);

  // R3
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |-> ($countones(frame_word) % 2 == 1));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_busy |-> !ser_out);

  for (genvar g = 0; g < NPIX; g++) begin : g_px
    // R6
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_load && force_msb[g] && !force_lsb[g]) |-> !frame_word[g+1]);
    // R6
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_load && force_msb[g] && force_lsb[g]) |-> frame_word[g+1]);
    // R7
    stretch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pix_trig[g]) |=> trig_held[g]);
  end

  logic unused_ok;
  assign unused_ok = ^{test_pat};
endmodule

bind ptl_tx ptl_tx_chk #(.NPIX(NPIX)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_tick(frame_tick),
  .pix_trig  (pix_trig),
  .force_msb (force_msb),
  .force_lsb (force_lsb),
  .test_pat  (test_pat),
  .ser_out   (ser_out),
  .trig_held (trig_held),
  .frame_word(frame_word),
  .frame_load(frame_load),
  .link_busy (link_busy)
);

// File: tb/ptl_tx_tb.sv
module ptl_tx_tb_top;
  localparam int CLK_PERIOD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic [21:0] pix_trig = '0;
  logic [21:0] force_msb = '0;
  logic [21:0] force_lsb = '0;
  logic [21:0] test_pat = '0;
  logic        ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptl_tx dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .pix_trig(pix_trig), .force_msb(force_msb), .force_lsb(force_lsb),
    .test_pat(test_pat), .ser_out(ser_out)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected frame, written from the requirements
  function automatic logic [23:0] ref_word(input logic [21:0] p, input logic [21:0] m,
                                           input logic [21:0] l, input logic [21:0] t);
    logic [23:0] w;
    int ones = 1;
    w[23] = 1'b1;
    for (int i = 0; i < 22; i++) begin
      logic b;
      if (m[i]) b = l[i];
      else      b = l[i] ? t[i] : p[i];
      w[i+1] = b;
      ones += int'(b);
    end
    w[0] = (ones % 2 == 0);
    return w;
  endfunction

  // Behavioural reference model of the line
  int   hold_left [22];
  logic raw_prev  [22];
  logic exp_q[$];
  logic exp_bit = 1'b0;
  logic [21:0] held_now;
  logic [23:0] mw;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 22; i++) begin hold_left[i] = 0; raw_prev[i] = 1'b0; end
      exp_q.delete();
      exp_bit = 1'b0;
    end else begin
      for (int i = 0; i < 22; i++) begin
        held_now[i] = pix_trig[i] || (hold_left[i] > 0);
        if (pix_trig[i] && !raw_prev[i]) hold_left[i] = 23;
        else if (hold_left[i] > 0) hold_left[i]--;
        raw_prev[i] = pix_trig[i];
      end
      if (frame_tick) begin
        mw = ref_word(held_now, force_msb, force_lsb, test_pat);
        exp_q.delete();
        for (int b = 23; b >= 0; b--) exp_q.push_back(mw[b]);
      end
      exp_bit = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done)
      chk(ser_out === exp_bit, "R2 stream vs model", {31'b0, ser_out}, {31'b0, exp_bit});
  end

  // Called at a negedge; tick sampled at the next posedge
  task automatic send_frame(output logic [23:0] w);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    w[23] = ser_out;
    for (int i = 22; i >= 0; i--) begin
      @(negedge clk);
      w[i] = ser_out;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [23:0] w, e;
    logic [21:0] p0, m0, l0, t0;
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b0, "R9 reset low", {31'b0, ser_out}, 0);
    rst_n = 1'b1;
    repeat (10) begin
      @(negedge clk);
      chk(ser_out == 1'b0, "R9 idle before first tick", {31'b0, ser_out}, 0);
    end

    // R4 live pass, R1 start, R3 parity
    pix_trig = 22'h2A5C31;
    e = ref_word(pix_trig, '0, '0, '0);
    send_frame(w);
    chk(w[23] == 1'b1, "R1 start bit", {31'b0, w[23]}, 1);
    chk(w == e, "R4 live frame", {8'b0, w}, {8'b0, e});
    chk(($countones(w) % 2) == 1, "R3 odd parity", {8'b0, w}, {8'b0, e});
    chk(w[22:1] == 22'h2A5C31, "R2 pixel field", {10'b0, w[22:1]}, 32'h2A5C31);

    // R5 test pattern substitution
    force_lsb = '1; test_pat = 22'h155AA3;
    send_frame(w);
    chk(w[22:1] == 22'h155AA3, "R5 pattern bits", {10'b0, w[22:1]}, 32'h155AA3);
    chk(($countones(w) % 2) == 1, "R3 odd parity pattern", {8'b0, w}, 0);

    // R6 force low
    pix_trig = '1; force_msb = '1; force_lsb = '0;
    send_frame(w);
    chk(w == 24'h800000, "R6 force low", {8'b0, w}, 32'h800000);

    // R6 force high
    pix_trig = '0; force_lsb = '1;
    send_frame(w);
    chk(w == 24'hFFFFFE, "R6 force high", {8'b0, w}, 32'hFFFFFE);

    // R4 R5 R6 mixed codes
    pix_trig = 22'h3C0F96; force_msb = 22'h0F0F0F; force_lsb = 22'h333333; test_pat = 22'h2D2D2D;
    e = ref_word(pix_trig, force_msb, force_lsb, test_pat);
    send_frame(w);
    chk(w == e, "R6 mixed override codes", {8'b0, w}, {8'b0, e});

    // R10 inputs change during a frame
    p0 = 22'h012345; m0 = 22'h000F00; l0 = 22'h0F00F0; t0 = 22'h3FFFFF;
    pix_trig = p0; force_msb = m0; force_lsb = l0; test_pat = t0;
    e = ref_word(p0, m0, l0, t0);
    fork
      send_frame(w);
      begin
        repeat (5) @(negedge clk);
        pix_trig = ~p0; force_msb = '0; force_lsb = '1; test_pat = '0;
      end
    join
    chk(w == e, "R10 frame frozen at tick", {8'b0, w}, {8'b0, e});

    // R7 one-clock pulse between ticks
    pix_trig = '0; force_msb = '0; force_lsb = '0; test_pat = '0;
    send_frame(w);
    fork
      send_frame(w);
      begin
        repeat (19) @(negedge clk);
        pix_trig[3] = 1'b1;
        @(negedge clk);
        pix_trig[3] = 1'b0;
      end
    join
    chk(w[4] == 1'b0, "R7 pulse not in earlier frame", {31'b0, w[4]}, 0);
    send_frame(w);
    chk(w[4] == 1'b1, "R7 stretched pulse captured", {31'b0, w[4]}, 1);
    send_frame(w);
    chk(w[4] == 1'b0, "R7 stretch released", {31'b0, w[4]}, 0);

    // R8 long trigger across two ticks
    pix_trig[5] = 1'b1;
    send_frame(w);
    chk(w[6] == 1'b1, "R8 first frame", {31'b0, w[6]}, 1);
    send_frame(w);
    chk(w[6] == 1'b1, "R8 second frame", {31'b0, w[6]}, 1);
    pix_trig[5] = 1'b0;
    send_frame(w);
    chk(w[6] == 1'b0, "R8 cleared after fall", {31'b0, w[6]}, 0);

    // R9 idle after last frame
    repeat (30) begin
      @(negedge clk);
      chk(ser_out == 1'b0, "R9 idle after frame", {31'b0, ser_out}, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule